// File: doc/BRIEF.md
# Single-Shot Pulse Timer

This block is one timer channel that emits exactly one pulse each time it is armed. Its central state is a run flag, and that flag is itself the output pulse. Software can raise the flag through a register write. A rising edge on an external trigger pin can also raise it, once the pin has passed through a synchronizer. A counter restarts from zero whenever the flag goes from low to high.

The pulse ends in one of two ways. Software can write the flag back to zero. Otherwise the counter reaches the programmed compare value, which drops the flag and sets a sticky interrupt flag. As a result, the pulse width in clock cycles equals the compare value.

The channel behaves this way only when its mode field and its output-control field both select single-shot operation. With any other setting, the output stays low and neither the trigger nor the compare logic acts. Software clears the interrupt flag by writing a one to it. The block has an asynchronous active-low reset, which is released synchronously inside the block.

Top module: `oneshot_timer`

## Requirements
- R1: After reset, pulse_out and irq_flag are 0 and the channel is idle.
- R2: The control word at address 0 carries the run bit in bit 0, the mode field in bits [2:1] and the output-control field in bits [4:3]. Single-shot operation needs mode = 2'b10 and output-control = 2'b11. With any other value, pulse_out stays 0, the trigger is ignored and irq_flag is never set.
- R3: A control write with bit 0 = 1 while the channel is idle drives pulse_out high from the clock edge that takes the write.
- R4: If trig_in rises before clock edge E1, the synchronizer and edge detector make pulse_out high after edge E3, provided the channel was idle and single-shot mode is selected.
- R5: A trigger edge that arrives while a pulse is active has no effect on the width of that pulse.
- R6: The compare value is written at address 1, bits [9:0]. The pulse lasts exactly that many clock cycles. A compare value of 0 gives a pulse one cycle wide.
- R7: When the pulse ends on a compare match, the run bit clears and irq_flag is set on the same clock edge.
- R8: A control write with bit 0 = 0 during a pulse ends it on that edge and leaves irq_flag at 0.
- R9: The counter restarts from zero on every rising edge of the run bit, so a pulse that starts after an early-cleared pulse still lasts the full compare value.
- R10: irq_flag is sticky. Writing address 3 with bit 0 = 1 clears it, and writing 0 there leaves it set. A compare match in the same cycle as a clear leaves it set.
- R11: Writes to address 2 (period compare), and to control bits 5 (counter-clear select) and 6 (duty/period swap), do not change the pulse width.
- R12: A control write with bit 0 = 1 during an active pulse does not restart the counter, so the pulse width stays the compare value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 control, 1 compare, 2 period, 3 interrupt clear |
| wr_data | input | CNT_W | Write data |
| trig_in | input | 1 | Asynchronous external start trigger |
| pulse_out | output | 1 | Single-shot pulse output |
| irq_flag | output | 1 | Sticky compare-match interrupt flag |

## Verification
The bench builds the block with its defaults: a 10-bit counter and a two-stage trigger synchronizer. With these values the full-scale compare value of 1023 gives a pulse of about a thousand cycles, so the largest width is measured directly. The fixed three-edge trigger latency can also be sampled cycle by cycle. Against the per-cycle reference, the bench runs several cases: a clear that lands on the same edge as a compare match, trigger edges during a pulse, early clears followed by a restart, and writes to the fields that have no effect.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_CMP   = 2'd1;
  localparam logic [1:0] ADDR_PER   = 2'd2;
  localparam logic [1:0] ADDR_IRQCL = 2'd3;

  localparam int RUN_BIT   = 0;
  localparam int MODE_LSB  = 1;
  localparam int OCTL_LSB  = 3;
  localparam int CTRL_BITS = 7;

  localparam logic [1:0] MODE_SINGLE = 2'b10;
  localparam logic [1:0] OCTL_SINGLE = 2'b11;

  typedef struct packed {
    logic [1:0] mode;
    logic [1:0] octl;
  } ctrl_t;
endpackage

// File: rtl/ost_trig_sync.sv
module ost_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic trig_rise
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  generate
    for (genvar g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        assign chain_d[g] = trig_in;
      end else begin : g_next
        assign chain_d[g] = chain_q[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign trig_rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R4: an edge is reported for a single cycle only
  assert_edge_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trig_rise |=> !trig_rise);
endmodule

// File: rtl/ost_regs.sv
module ost_regs
  import oneshot_pkg::*;
#(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             match,
  output logic             run_wr,
  output logic             run_val,
  output logic             mode_ok,
  output logic [CNT_W-1:0] cmp_q,
  output logic             irq_q
);
  ctrl_t            ctrl_q, ctrl_d;
  logic [CNT_W-1:0] cmp_d;
  logic             irq_d;
  logic             ctrl_we, cmp_we, irq_clr;

  always_comb begin
    ctrl_we = wr_en && (wr_addr == ADDR_CTRL);
    cmp_we  = wr_en && (wr_addr == ADDR_CMP);
    irq_clr = wr_en && (wr_addr == ADDR_IRQCL) && wr_data[0];
    ctrl_d  = ctrl_q;
    if (ctrl_we) begin
      ctrl_d.mode = wr_data[MODE_LSB +: 2];
      ctrl_d.octl = wr_data[OCTL_LSB +: 2];
    end
    cmp_d = cmp_we ? wr_data : cmp_q;
    irq_d = irq_q;
    if (irq_clr) irq_d = 1'b0;
    if (match)   irq_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cmp_q  <= '0;
      irq_q  <= 1'b0;
    end else begin
      ctrl_q <= ctrl_d;
      cmp_q  <= cmp_d;
      irq_q  <= irq_d;
    end
  end

  assign run_wr  = ctrl_we;
  assign run_val = wr_data[RUN_BIT];
  assign mode_ok = (ctrl_q.mode == MODE_SINGLE) && (ctrl_q.octl == OCTL_SINGLE);

  // R10: the flag stays set unless a clear write arrives
  assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q);
  // R10: a match wins over a clear in the same cycle
  assert_irq_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> irq_q);
endmodule

// File: rtl/ost_core.sv
module ost_core #(
  parameter int CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_ok,
  input  logic             trig_rise,
  input  logic             run_wr,
  input  logic             run_val,
  input  logic [CNT_W-1:0] cmp,
  output logic             run_q,
  output logic             match
);
  localparam int EXT_W = CNT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             run_d;
  logic             start;
  logic [EXT_W-1:0] cnt_plus1;

  always_comb begin
    cnt_plus1 = {1'b0, cnt_q} + EXT_W'(1);
    match     = run_q && mode_ok && (cnt_plus1 >= {1'b0, cmp});
    run_d     = run_q;
    if (trig_rise && !run_q && mode_ok) run_d = 1'b1;
    if (run_wr)                         run_d = run_val;
    if (match)                          run_d = 1'b0;
    start = run_d && !run_q;
    if (start)      cnt_d = '0;
    else if (run_q) cnt_d = cnt_q + CNT_W'(1);
    else            cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  // R7: a compare match always ends the run
  assert_match_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> !run_q);
  // R9: counting restarts from zero on each rising edge of run
  assert_restart_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> (cnt_q == '0));
  // R12: while run stays high the count only advances by one
  assert_no_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && $past(run_q)) |-> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/oneshot_timer.sv
module oneshot_timer #(
  parameter int CNT_W       = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic             trig_in,
  output logic             pulse_out,
  output logic             irq_flag
);
  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             trig_rise, run_wr, run_val, mode_ok, run_q, match, irq_q;
  logic [CNT_W-1:0] cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ost_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .trig_in(trig_in), .trig_rise(trig_rise));

  ost_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .match(match), .run_wr(run_wr), .run_val(run_val),
    .mode_ok(mode_ok), .cmp_q(cmp_q), .irq_q(irq_q));

  ost_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_int_n), .mode_ok(mode_ok), .trig_rise(trig_rise),
    .run_wr(run_wr), .run_val(run_val), .cmp(cmp_q), .run_q(run_q),
    .match(match));

  assign pulse_out = run_q & mode_ok;
  assign irq_flag  = irq_q;

  // R2: outside single-shot mode no interrupt can be raised
  assert_no_irq_off_mode_R2: assert property (@(posedge clk) disable iff (!rst_int_n)
    (!mode_ok && !irq_flag) |=> !irq_flag);
  // R1: outputs idle while held in reset
  always_comb begin
    if (!rst_int_n) assert_reset_idle_R1: assert (!irq_flag);
  end
endmodule

// File: tb/tb_oneshot_timer.sv
module tb_oneshot_timer;
  localparam int CW = 10;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [CW-1:0] wr_data = '0;
  logic trig_in = 1'b0;
  logic pulse_out, irq_flag;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  oneshot_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .trig_in(trig_in), .pulse_out(pulse_out), .irq_flag(irq_flag));

  // behavioural reference model
  int m_mode, m_oct, m_cmp, m_cnt;
  bit m_run, m_irq;
  bit sq[$];

  always @(posedge clk) begin
    bit ok, edge_seen, mt, nr;
    if (!rst_n) begin
      m_mode = 0; m_oct = 0; m_cmp = 0; m_cnt = 0; m_run = 0; m_irq = 0;
      sq = '{0, 0, 0};
    end else begin
      ok = (m_mode == 2) && (m_oct == 3);
      edge_seen = sq[1] && !sq[2];
      mt = m_run && ok && (m_cnt + 1 >= m_cmp);
      nr = m_run;
      if (edge_seen && !m_run && ok) nr = 1;
      if (wr_en && wr_addr == 0) nr = wr_data[0];
      if (mt) nr = 0;
      if (nr && !m_run) m_cnt = 0;
      else if (m_run) m_cnt = (m_cnt + 1) % 1024;
      if (wr_en && wr_addr == 3 && wr_data[0]) m_irq = 0;
      if (mt) m_irq = 1;
      if (wr_en && wr_addr == 0) begin
        m_mode = int'(wr_data[2:1]); m_oct = int'(wr_data[4:3]);
      end
      if (wr_en && wr_addr == 1) m_cmp = int'(wr_data);
      m_run = nr;
      sq.push_front(trig_in);
      void'(sq.pop_back());
    end
  end

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit exp_p;
      exp_p = m_run && (m_mode == 2) && (m_oct == 3);
      check(pulse_out == exp_p, "MODEL pulse", int'(pulse_out), int'(exp_p));
      check(irq_flag == m_irq, "MODEL irq", int'(irq_flag), int'(m_irq));
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [CW-1:0] ctl(input bit run);
    return CW'(28) | CW'(run);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // counts high cycles from the current negedge; optional mid-pulse write or trigger
  task automatic measure(input int at, input bit use_trig, input logic [1:0] a,
                         input logic [CW-1:0] d, output int w);
    w = 0;
    for (int i = 0; i < 3000; i++) begin
      if (pulse_out) w++;
      else break;
      wr_en = (!use_trig && w == at);
      wr_addr = a; wr_data = d;
      trig_in = use_trig && (w >= at) && (w < at + 3);
      @(negedge clk);
    end
    wr_en = 1'b0; trig_in = 1'b0;
  endtask

  task automatic shot(input int cmpv, input logic [CW-1:0] cw, input int at,
                      input bit use_trig, input logic [1:0] a, input logic [CW-1:0] d,
                      output int w);
    wr(2'd1, CW'(cmpv));
    wr(2'd3, CW'(1));
    wr(2'd0, cw);
    measure(at, use_trig, a, d, w);
  endtask

  initial begin
    int w;
    repeat (4) @(negedge clk);
    check(pulse_out == 1'b0, "R1 pulse after reset", int'(pulse_out), 0);
    check(irq_flag == 1'b0, "R1 irq after reset", int'(irq_flag), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    shot(5, ctl(1), -1, 0, 0, 0, w);
    check(w == 5, "R6 width cmp=5", w, 5);
    check(irq_flag == 1'b1, "R7 irq after match", int'(irq_flag), 1);

    shot(0, ctl(1), -1, 0, 0, 0, w);
    check(w == 1, "R6 width cmp=0", w, 1);
    shot(1, ctl(1), -1, 0, 0, 0, w);
    check(w == 1, "R3 start and width cmp=1", w, 1);

    shot(30, ctl(1), 4, 0, 2'd0, ctl(0), w);
    check(w == 4, "R8 early clear width", w, 4);
    check(irq_flag == 1'b0, "R8 no irq on clear", int'(irq_flag), 0);

    shot(10, ctl(1), 3, 0, 2'd0, ctl(0), w);
    wr(2'd0, ctl(1));
    measure(-1, 0, 0, 0, w);
    check(w == 10, "R9 restart full width", w, 10);

    shot(12, ctl(1), 3, 0, 2'd0, ctl(1), w);
    check(w == 12, "R12 rewrite run no restart", w, 12);

    shot(20, ctl(1), 5, 1, 0, 0, w);
    check(w == 20, "R5 trigger during pulse", w, 20);
    repeat (6) @(negedge clk);
    check(pulse_out == 1'b0, "R5 no late start", int'(pulse_out), 0);

    wr(2'd2, CW'(2));
    shot(9, CW'(125), -1, 0, 0, 0, w);
    check(w == 9, "R11 period and unused bits", w, 9);

    // R4 trigger latency
    wr(2'd1, CW'(7));
    wr(2'd0, ctl(0));
    trig_in = 1'b1;
    @(negedge clk);
    check(pulse_out == 1'b0, "R4 after E1", int'(pulse_out), 0);
    @(negedge clk);
    check(pulse_out == 1'b0, "R4 after E2", int'(pulse_out), 0);
    @(negedge clk);
    check(pulse_out == 1'b1, "R4 after E3", int'(pulse_out), 1);
    measure(-1, 0, 0, 0, w);
    check(w == 7, "R4 triggered width", w, 7);
    trig_in = 1'b0;
    repeat (3) @(negedge clk);

    // R10 clear behaviour
    wr(2'd3, CW'(0));
    check(irq_flag == 1'b1, "R10 write zero keeps flag", int'(irq_flag), 1);
    wr(2'd3, CW'(1));
    check(irq_flag == 1'b0, "R10 write one clears", int'(irq_flag), 0);
    shot(6, ctl(1), 6, 0, 2'd3, CW'(1), w);
    check(w == 6, "R10 width with clear on match", w, 6);
    check(irq_flag == 1'b1, "R10 set wins over clear", int'(irq_flag), 1);

    // R2 wrong mode
    wr(2'd3, CW'(1));
    wr(2'd1, CW'(3));
    wr(2'd0, CW'(24 | 2 | 1));
    repeat (8) @(negedge clk);
    check(pulse_out == 1'b0, "R2 wrong mode no pulse", int'(pulse_out), 0);
    check(irq_flag == 1'b0, "R2 wrong mode no irq", int'(irq_flag), 0);
    wr(2'd0, CW'(4 | 8 | 0));
    trig_in = 1'b1;
    repeat (6) @(negedge clk);
    check(pulse_out == 1'b0, "R2 trigger ignored off mode", int'(pulse_out), 0);
    trig_in = 1'b0;
    wr(2'd0, ctl(0));
    repeat (3) @(negedge clk);

    shot(1023, ctl(1), -1, 0, 0, 0, w);
    check(w == 1023, "R6 full-scale width", w, 1023);

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule